// File: doc/BRIEF.md
# Banked Code Address Mapper

This block sits between an 8-bit processor core and a banked flash array whose size exceeds the core's 16-bit code space. The lower half of the logical code space, addresses 0x0000 to 0x7FFF, is shared and always lands in bank 0. The upper half, addresses 0x8000 to 0xFFFF, is a window that can be pointed at any implemented bank. Instruction fetches and constant traffic each have their own selector for that window. Constant traffic means table reads and flash-bound writes on the data-move path. Each path therefore gets its own 17-bit physical address, built as the bank number concatenated with logical bits [14:0].

Both selectors live in one 8-bit special-function register. The register sits at SFR address 0x84 and is decoded the same way on every SFR page. The block also guards the fetch selector. A write may change it only when the writing instruction was itself fetched from bank 0, which the core reports on `exec_bank` alongside the write strobe. A parameter sets how many banks exist (2, 3 or 4). A write that names a missing bank leaves that one field unchanged.

Top module: `bank_addr_map`

## Requirements
- R1: A logical address with bit 15 clear maps to physical `{2'b00, addr[14:0]}` on both paths, whatever either selector holds.
- R2: A fetch address with bit 15 set maps to `{fetch_sel, addr[14:0]}`, where the fetch selector is register bits [1:0] and value n selects bank n.
- R3: A constant address with bit 15 set maps to `{const_sel, addr[14:0]}`, where the constant selector is register bits [5:4].
- R4: After reset both selectors are 00, so the register reads 0x00 and every access maps to bank 0.
- R5: Only SFR address 0x84 is decoded. A write to any other address changes nothing, and a read of any other address returns 0x00 on `sfr_rdata`.
- R6: `sfr_rdata` is combinational and holds `{2'b00, const_sel, 2'b00, fetch_sel}` while address 0x84 is presented. Reserved bits [7:6] and [3:2] always read 0, whatever was written to them.
- R7: A write updates the fetch selector only when `exec_bank` is 00 in the cycle of the strobe. Otherwise the fetch selector keeps its value, while the constant selector still updates.
- R8: A field written with a bank number equal to or greater than `NUM_BANKS` keeps its old value. The other field of the same write still updates if its value is in range.
- R9: A write takes effect at the clock edge that samples the strobe. Translations in the strobe cycle still use the old selector values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wr | input | 1 | SFR write strobe, one cycle per write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for the presented address |
| exec_bank | input | 2 | Bank the instruction issuing the current SFR write was fetched from |
| fetch_addr | input | 16 | Logical instruction fetch address |
| fetch_paddr | output | 17 | Physical instruction fetch address |
| const_addr | input | 16 | Logical constant or flash-write address |
| const_paddr | output | 17 | Physical constant or flash-write address |

## Verification
Both translated addresses and the read data depend only on the present inputs and the register, so the bench samples them a quarter period after driving at the falling edge, with no clock edge in between. A register write takes effect one rising edge after its strobe. The bench therefore updates its model at that edge and compares the new selectors in the next cycle's sample. During the strobe cycle itself, it expects the old mapping. After reset is released, two synchronizer stages pass before the first write is issued.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int BANK_W = 2;

  typedef logic [BANK_W-1:0] bank_t;

  typedef struct packed {
    bank_t co;   // constant-access selector
    bank_t fi;   // instruction-fetch selector
  } bank_sel_t;

  function automatic logic bank_ok(input bank_t b, input int nb);
    return int'(b) < nb;
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/bank_sel_reg.sv
module bank_sel_reg
  import bank_map_pkg::*;
#(
  parameter int         NUM_BANKS = 4,
  parameter logic [7:0] SFR_ADDR  = 8'h84
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [7:0] sfr_addr,
  input  logic      sfr_wr,
  input  logic [7:0] sfr_wdata,
  input  bank_t     exec_bank,
  output bank_sel_t sel_q,
  output logic [7:0] sfr_rdata
);
  localparam int CO_LSB = 4;
  localparam int FI_LSB = 0;

  logic  wr_hit;
  logic  co_en, fi_en;
  bank_t co_d, fi_d;
  logic  rsvd_unused;

  // next-state
  always_comb begin
    wr_hit = sfr_wr && (sfr_addr == SFR_ADDR);
    co_d   = sfr_wdata[CO_LSB +: BANK_W];
    fi_d   = sfr_wdata[FI_LSB +: BANK_W];
    co_en  = wr_hit && bank_ok(co_d, NUM_BANKS);
    fi_en  = wr_hit && (exec_bank == '0) && bank_ok(fi_d, NUM_BANKS);
  end

  assign rsvd_unused = ^{sfr_wdata[7:6], sfr_wdata[3:2]};

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      if (co_en) sel_q.co <= co_d;
      if (fi_en) sel_q.fi <= fi_d;
    end
  end

  // read path
  always_comb begin
    sfr_rdata = '0;
    if (sfr_addr == SFR_ADDR) begin
      sfr_rdata[CO_LSB +: BANK_W] = sel_q.co;
      sfr_rdata[FI_LSB +: BANK_W] = sel_q.fi;
    end
  end

  assert_fetch_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == SFR_ADDR && exec_bank != '0) |=> $stable(sel_q.fi));

  assert_const_updates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == SFR_ADDR && int'(sfr_wdata[5:4]) < NUM_BANKS)
      |=> sel_q.co == $past(sfr_wdata[5:4]));

  assert_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_q.co) < NUM_BANKS && int'(sel_q.fi) < NUM_BANKS);

  assert_no_stray_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_wr && sfr_addr == SFR_ADDR) |=> $stable(sel_q));
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import bank_map_pkg::*;
#(
  parameter int LOG_W = 16
) (
  input  logic [LOG_W-1:0]      laddr,
  input  bank_t                 sel,
  output logic [BANK_W+LOG_W-2:0] paddr
);
  localparam int OFS_W = LOG_W - 1;

  bank_t bank;

  always_comb begin
    bank  = laddr[LOG_W-1] ? sel : '0;
    paddr = {bank, laddr[OFS_W-1:0]};
  end
endmodule

// File: rtl/bank_addr_map.sv
module bank_addr_map
  import bank_map_pkg::*;
#(
  parameter int         NUM_BANKS = 4,
  parameter int         LOG_W     = 16,
  parameter logic [7:0] SFR_ADDR  = 8'h84
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         sfr_addr,
  input  logic               sfr_wr,
  input  logic [7:0]         sfr_wdata,
  output logic [7:0]         sfr_rdata,
  input  logic [1:0]         exec_bank,
  input  logic [LOG_W-1:0]   fetch_addr,
  output logic [LOG_W:0]     fetch_paddr,
  input  logic [LOG_W-1:0]   const_addr,
  output logic [LOG_W:0]     const_paddr
);
  localparam int PHYS_W = BANK_W + LOG_W - 1;
  localparam int NPATH  = 2;

  logic      rst_n_s;
  bank_sel_t sel_q;

  logic [LOG_W-1:0]  path_la [NPATH];
  bank_t             path_sel[NPATH];
  logic [PHYS_W-1:0] path_pa [NPATH];

  rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  bank_sel_reg #(.NUM_BANKS(NUM_BANKS), .SFR_ADDR(SFR_ADDR)) u_sel_reg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .exec_bank (exec_bank),
    .sel_q     (sel_q),
    .sfr_rdata (sfr_rdata)
  );

  assign path_la[0]  = fetch_addr;
  assign path_sel[0] = sel_q.fi;
  assign path_la[1]  = const_addr;
  assign path_sel[1] = sel_q.co;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    addr_xlate #(.LOG_W(LOG_W)) u_xlate (
      .laddr (path_la[p]),
      .sel   (path_sel[p]),
      .paddr (path_pa[p])
    );
  end

  assign fetch_paddr = path_pa[0];
  assign const_paddr = path_pa[1];

  assert_low_window_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!fetch_addr[LOG_W-1] |-> fetch_paddr[PHYS_W-1 -: BANK_W] == '0) and
    (!const_addr[LOG_W-1] |-> const_paddr[PHYS_W-1 -: BANK_W] == '0));

  assert_fetch_window_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fetch_addr[LOG_W-1] && sfr_addr == SFR_ADDR)
      |-> fetch_paddr[PHYS_W-1 -: BANK_W] == sfr_rdata[1:0]);

  assert_const_window_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (const_addr[LOG_W-1] && sfr_addr == SFR_ADDR)
      |-> const_paddr[PHYS_W-1 -: BANK_W] == sfr_rdata[5:4]);

  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    fetch_paddr[LOG_W-2:0] == fetch_addr[LOG_W-2:0] &&
    const_paddr[LOG_W-2:0] == const_addr[LOG_W-2:0]);

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    sfr_rdata[7:6] == 2'b00 && sfr_rdata[3:2] == 2'b00);
endmodule

// File: tb/test_bank_addr_map.sv
module test_bank_addr_map;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        sfr_wr;
  logic [1:0]  exec_bank;
  logic [15:0] fetch_addr, const_addr;
  logic [16:0] fetch_paddr, const_paddr;

  int total = 0;
  int bad = 0;
  logic [1:0] m_co = 2'b00;
  logic [1:0] m_fi = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_addr_map #(.NUM_BANKS(NB)) i_bank_addr_map (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .exec_bank(exec_bank),
    .fetch_addr(fetch_addr), .fetch_paddr(fetch_paddr),
    .const_addr(const_addr), .const_paddr(const_paddr)
  );

  function automatic logic [16:0] xl(input logic [15:0] a, input logic [1:0] s);
    return {(a[15] ? s : 2'b00), a[14:0]};
  endfunction

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] a, input logic [7:0] d,
                      input logic [1:0] ex, input logic [15:0] fa, input logic [15:0] ca,
                      input string rtag, input string xtag);
    string ft, ct;
    @(negedge clk);
    sfr_wr = wr; sfr_addr = a; sfr_wdata = d; exec_bank = ex;
    fetch_addr = fa; const_addr = ca;
    #(CLK_PERIOD/4);
    ft = (xtag != "") ? xtag : (fa[15] ? "R2" : "R1");
    ct = (xtag != "") ? xtag : (ca[15] ? "R3" : "R1");
    chk(ft, fetch_paddr, xl(fa, m_fi));
    chk(ct, const_paddr, xl(ca, m_co));
    chk(rtag, {9'd0, sfr_rdata}, {9'd0, (a == 8'h84) ? {2'b00, m_co, 2'b00, m_fi} : 8'h00});
    @(posedge clk);
    if (wr && a == 8'h84) begin
      if (int'(d[5:4]) < NB) m_co = d[5:4];
      if (ex == 2'b00 && int'(d[1:0]) < NB) m_fi = d[1:0];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; sfr_wr = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00;
    exec_bank = 2'b00; fetch_addr = 16'h0000; const_addr = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R4: reset state
    step(1'b0, 8'h84, 8'h00, 2'b00, 16'h8000, 16'hFFFF, "R4", "R4");
    // R5: other addresses neither written nor read
    step(1'b1, 8'h85, 8'h11, 2'b00, 16'h8001, 16'h8002, "R5", "R5");
    step(1'b0, 8'h84, 8'h00, 2'b00, 16'h8003, 16'hC004, "R5", "R5");
    step(1'b0, 8'h85, 8'h00, 2'b00, 16'h8003, 16'hC004, "R5", "");
    // R9: same-cycle translation uses old value
    step(1'b1, 8'h84, 8'h21, 2'b00, 16'h9000, 16'hA000, "R9", "R9");
    step(1'b0, 8'h84, 8'h00, 2'b00, 16'h9234, 16'hA555, "R9", "");
    // R6: reserved bits read zero
    step(1'b1, 8'h84, 8'hED, 2'b00, 16'h1000, 16'h2000, "R6", "");
    step(1'b0, 8'h84, 8'h00, 2'b00, 16'hF000, 16'hF001, "R6", "");
    // R7: fetch selector locked outside bank 0
    step(1'b1, 8'h84, 8'h02, 2'b01, 16'h8000, 16'h8000, "R7", "");
    step(1'b0, 8'h84, 8'h00, 2'b00, 16'h8100, 16'h8200, "R7", "");
    step(1'b1, 8'h84, 8'h10, 2'b10, 16'h8000, 16'h8000, "R7", "");
    step(1'b0, 8'h84, 8'h00, 2'b00, 16'h8300, 16'h8400, "R7", "");
    // R8: out-of-range field ignored, other field still updates
    step(1'b1, 8'h84, 8'h33, 2'b00, 16'h8000, 16'h8000, "R8", "");
    step(1'b0, 8'h84, 8'h00, 2'b00, 16'hFFFF, 16'hFFFF, "R8", "");
    step(1'b1, 8'h84, 8'h32, 2'b00, 16'h8000, 16'h8000, "R8", "");
    step(1'b0, 8'h84, 8'h00, 2'b00, 16'hFFFF, 16'hFFFF, "R8", "");
    // R1: lower window ignores selectors
    step(1'b0, 8'h84, 8'h00, 2'b00, 16'h7FFF, 16'h0000, "R6", "R1");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = ($urandom % 5 != 0) ? 8'h84 : 8'($urandom);
      step(1'($urandom), a, 8'($urandom), 2'($urandom % 3 == 0 ? 0 : $urandom),
           16'($urandom), 16'($urandom), (a == 8'h84) ? "R6" : "R5", "");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule